// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the fetch address of an instruction stream into a physical address in one registered stage. It takes a 64-bit fetch address and picks one of five paths. Addresses marked as privileged code bypass the translation. A physical-mode flag passes the address through unchanged. Malformed virtual addresses are rejected. A kernel-only superpage window maps directly. Every other address is looked up in an attached translation buffer. The buffer is queried combinationally with the virtual page number and the address-space number, and it answers in the same cycle with hit, page frame and per-mode read enables.

One cycle after a request, the block presents the physical address, a two-bit fault code and an uncacheable flag. An access violation or a buffer miss also loads a fault-tag register with the fetch address, and a formatted register with the page-table base ORed with the virtual page number shifted left by three. Three counters record permitted hits, misses and access violations. The translation buffer and its refill live outside this block.

Top module: `ift_xlate`

## Requirements
- R1: After reset, rsp_valid_o, paddr_o, fault_o, uncached_o, fault_tag_o, fault_form_o and all three counters are zero.
- R2: A request (req_valid_i high) is answered on the next clock edge with rsp_valid_o high. Without a request, rsp_valid_o is low on the next edge, and no counter or fault register changes.
- R3: If vaddr_i bit 0 is 1 (privileged code), this path wins over all others. paddr_o is vaddr_i with bits 1:0 cleared and bits 63:44 cleared, fault_o is 0, uncached_o is 0, and the hit counter increments.
- R4: With phys_mode_i high (and bit 0 clear), the physical address equals vaddr_i unchanged.
- R5: If bits 63:42 of vaddr_i are not all equal, the fault is an access violation (fault_o=1). This does not apply on the R3 or R4 paths.
- R6: If sp_en_i bit 1 is 1 and vaddr_i[42:41]=2'b10, the superpage window applies. In kernel mode (mode_i=0) the result is vaddr_i[43:0]. If its bit 39 or bit 40 is 1, bits 43:40 are forced to 1; otherwise bits 63:40 are cleared. No counter changes.
- R7: A superpage access with mode_i other than 0 gives fault_o=1.
- R8: Otherwise the buffer is used. If tb_hit_i is low, fault_o=2. On a hit with tb_rd_en_i[mode_i] low, fault_o=1. On a permitted hit, paddr_o = {tb_pfn_i, vaddr_i[12:2], 2'b00} and the hit counter increments. Mode codes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R9: On the R4, R6 and R8-hit paths, any result bit above bit 43 gives fault_o=3 (machine check), with paddr_o holding the offending address. Otherwise uncached_o = result bit 39 OR bit 40. uncached_o is 0 on every fault. On fault codes 1 and 2, paddr_o is 0.
- R10: On fault codes 1 and 2, fault_tag_o takes vaddr_i and fault_form_o takes ptbr_i | (vaddr_i[42:13] << 3). On any other outcome, both registers hold.
- R11: The miss counter increments on each fault_o=2. The violation counter increments on each fault_o=1. The physical and superpage paths never touch the hit counter.
- R12: tb_vpn_o equals vaddr_i[42:13] and tb_asn_o equals asn_i, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| vaddr_i | input | 64 | Fetch address |
| phys_mode_i | input | 1 | Pass address through untranslated |
| mode_i | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| sp_en_i | input | 2 | Superpage enable field (bit 1 used) |
| asn_i | input | 8 | Current address-space number |
| ptbr_i | input | 64 | Page-table base for the formatted fault address |
| tb_vpn_o | output | 30 | Virtual page number sent to the buffer |
| tb_asn_o | output | 8 | Address-space number sent to the buffer |
| tb_hit_i | input | 1 | Buffer hit |
| tb_pfn_i | input | 31 | Page frame of the hit entry |
| tb_rd_en_i | input | 4 | Per-mode read enables of the hit entry |
| rsp_valid_o | output | 1 | Response present |
| paddr_o | output | 64 | Physical address |
| fault_o | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| uncached_o | output | 1 | Access is uncacheable |
| fault_tag_o | output | 64 | Last faulting fetch address |
| fault_form_o | output | 64 | Last formatted fault address |
| hit_cnt_o | output | 32 | Hit count |
| miss_cnt_o | output | 32 | Miss count |
| acv_cnt_o | output | 32 | Access violation count |

## Verification
The assertions check several rules on every cycle. Each counter moves by exactly one, and only together with the matching fault code. The fault registers change only on violations or misses. A faulting response is never uncacheable. A clean response stays inside the implemented physical range. An idle cycle yields no response. The bench scenarios cover what only concrete values can show: the path priority, the exact address arithmetic of the bypass, superpage and buffer paths, the sign extension into the I/O window, the formatted fault address, and whether a physical-mode address is accepted or raises a machine check.

// File: rtl/ift_pkg.sv
package ift_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2,
    FLT_MCHK = 2'd3
  } ift_fault_e;

  typedef enum logic [2:0] {
    PATH_PRIV  = 3'd0,
    PATH_PHYS  = 3'd1,
    PATH_BADVA = 3'd2,
    PATH_SPAGE = 3'd3,
    PATH_TB    = 3'd4
  } ift_path_e;

  localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/ift_route.sv
module ift_route
  import ift_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 43
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            phys_mode_i,
  input  logic [1:0]      sp_en_i,
  output ift_path_e       path_o
);
  localparam int EXT_W = VA_W - VA_IMPL_W + 1;

  logic [EXT_W-1:0] ext;
  logic             va_ok;
  logic             in_spage;

  assign ext      = vaddr_i[VA_W-1:VA_IMPL_W-1];
  assign va_ok    = (&ext) | ~(|ext);
  assign in_spage = sp_en_i[1] && (vaddr_i[VA_IMPL_W-1:VA_IMPL_W-2] == 2'b10);

  always_comb begin
    if (vaddr_i[0])       path_o = PATH_PRIV;
    else if (phys_mode_i) path_o = PATH_PHYS;
    else if (!va_ok)      path_o = PATH_BADVA;
    else if (in_spage)    path_o = PATH_SPAGE;
    else                  path_o = PATH_TB;
  end
endmodule

// File: rtl/ift_form.sv
module ift_form
  import ift_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_IMPL_W = 44,
  parameter int OFS_W     = 13,
  parameter int SP_CUT    = 40,
  parameter int UC_LO     = 39,
  parameter int UC_HI     = 40,
  localparam int PFN_W    = PA_IMPL_W - OFS_W
) (
  input  ift_path_e        path_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       mode_i,
  input  logic             tb_hit_i,
  input  logic [PFN_W-1:0] tb_pfn_i,
  input  logic [3:0]       tb_rd_en_i,
  output logic [VA_W-1:0]  pa_o,
  output ift_fault_e       fault_o,
  output logic             uncached_o,
  output logic             inc_hit_o,
  output logic             inc_miss_o,
  output logic             inc_acv_o
);
  localparam int HI_W = VA_W - PA_IMPL_W;

  logic [VA_W-1:0] pa_sp;
  logic            chk;

  // superpage result with I/O window extension
  always_comb begin
    pa_sp = {{HI_W{1'b0}}, vaddr_i[PA_IMPL_W-1:0]};
    if (pa_sp[UC_LO] || pa_sp[UC_HI]) pa_sp[PA_IMPL_W-1:SP_CUT] = '1;
    else                               pa_sp[VA_W-1:SP_CUT]      = '0;
  end

  always_comb begin
    pa_o       = '0;
    fault_o    = FLT_NONE;
    uncached_o = 1'b0;
    inc_hit_o  = 1'b0;
    inc_miss_o = 1'b0;
    inc_acv_o  = 1'b0;
    chk        = 1'b0;
    unique case (path_i)
      PATH_PRIV: begin
        pa_o      = {{HI_W{1'b0}}, vaddr_i[PA_IMPL_W-1:2], 2'b00};
        inc_hit_o = 1'b1;
      end
      PATH_PHYS: begin
        pa_o = vaddr_i;
        chk  = 1'b1;
      end
      PATH_SPAGE: begin
        if (mode_i != MODE_KERNEL) begin
          fault_o   = FLT_ACV;
          inc_acv_o = 1'b1;
        end else begin
          pa_o = pa_sp;
          chk  = 1'b1;
        end
      end
      PATH_TB: begin
        if (!tb_hit_i) begin
          fault_o    = FLT_MISS;
          inc_miss_o = 1'b1;
        end else if (!tb_rd_en_i[mode_i]) begin
          fault_o   = FLT_ACV;
          inc_acv_o = 1'b1;
        end else begin
          pa_o      = {{HI_W{1'b0}}, tb_pfn_i, vaddr_i[OFS_W-1:2], 2'b00};
          inc_hit_o = 1'b1;
          chk       = 1'b1;
        end
      end
      default: begin
        fault_o   = FLT_ACV;
        inc_acv_o = 1'b1;
      end
    endcase
    if (chk) begin
      if (|pa_o[VA_W-1:PA_IMPL_W]) fault_o    = FLT_MCHK;
      else                          uncached_o = pa_o[UC_LO] | pa_o[UC_HI];
    end
  end
endmodule

// File: rtl/ift_state.sv
module ift_state
  import ift_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int VPN_W = 30,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [VA_W-1:0]  ptbr_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VA_W-1:0]  pa_i,
  input  ift_fault_e       fault_i,
  input  logic             uncached_i,
  input  logic [2:0]       inc_i,
  output logic             rsp_valid_o,
  output logic [VA_W-1:0]  paddr_o,
  output ift_fault_e       fault_o,
  output logic             uncached_o,
  output logic [VA_W-1:0]  fault_tag_o,
  output logic [VA_W-1:0]  fault_form_o,
  output logic [CNT_W-1:0] cnt_o [3]
);
  logic load_flt;
  assign load_flt = req_valid_i && (fault_i == FLT_ACV || fault_i == FLT_MISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= FLT_NONE;
      uncached_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        paddr_o    <= pa_i;
        fault_o    <= fault_i;
        uncached_o <= uncached_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_tag_o  <= '0;
      fault_form_o <= '0;
    end else if (load_flt) begin
      fault_tag_o  <= vaddr_i;
      fault_form_o <= ptbr_i | ({{(VA_W-VPN_W){1'b0}}, vpn_i} << 3);
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_o[k] <= '0;
      else if (req_valid_i && inc_i[k]) cnt_o[k] <= cnt_o[k] + 1'b1;
    end
  end
endmodule

// File: rtl/ift_xlate.sv
module ift_xlate
  import ift_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 43,
  parameter int PA_IMPL_W = 44,
  parameter int OFS_W     = 13,
  parameter int ASN_W     = 8,
  parameter int CNT_W     = 32,
  localparam int VPN_W    = VA_IMPL_W - OFS_W,
  localparam int PFN_W    = PA_IMPL_W - OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             phys_mode_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       sp_en_i,
  input  logic [ASN_W-1:0] asn_i,
  input  logic [VA_W-1:0]  ptbr_i,
  output logic [VPN_W-1:0] tb_vpn_o,
  output logic [ASN_W-1:0] tb_asn_o,
  input  logic             tb_hit_i,
  input  logic [PFN_W-1:0] tb_pfn_i,
  input  logic [3:0]       tb_rd_en_i,
  output logic             rsp_valid_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic [1:0]       fault_o,
  output logic             uncached_o,
  output logic [VA_W-1:0]  fault_tag_o,
  output logic [VA_W-1:0]  fault_form_o,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] acv_cnt_o
);
  ift_path_e       path;
  logic [VA_W-1:0] pa;
  ift_fault_e      flt_c, flt_q;
  logic            uc_c;
  logic [2:0]      inc;
  logic [CNT_W-1:0] cnt [3];

  assign tb_vpn_o = vaddr_i[VA_IMPL_W-1:OFS_W];
  assign tb_asn_o = asn_i;

  ift_route #(.VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W)) u_route (
    .vaddr_i     (vaddr_i),
    .phys_mode_i (phys_mode_i),
    .sp_en_i     (sp_en_i),
    .path_o      (path)
  );

  ift_form #(.VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W), .OFS_W(OFS_W)) u_form (
    .path_i     (path),
    .vaddr_i    (vaddr_i),
    .mode_i     (mode_i),
    .tb_hit_i   (tb_hit_i),
    .tb_pfn_i   (tb_pfn_i),
    .tb_rd_en_i (tb_rd_en_i),
    .pa_o       (pa),
    .fault_o    (flt_c),
    .uncached_o (uc_c),
    .inc_hit_o  (inc[0]),
    .inc_miss_o (inc[1]),
    .inc_acv_o  (inc[2])
  );

  ift_state #(.VA_W(VA_W), .VPN_W(VPN_W), .CNT_W(CNT_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .vaddr_i      (vaddr_i),
    .ptbr_i       (ptbr_i),
    .vpn_i        (tb_vpn_o),
    .pa_i         (pa),
    .fault_i      (flt_c),
    .uncached_i   (uc_c),
    .inc_i        (inc),
    .rsp_valid_o  (rsp_valid_o),
    .paddr_o      (paddr_o),
    .fault_o      (flt_q),
    .uncached_o   (uncached_o),
    .fault_tag_o  (fault_tag_o),
    .fault_form_o (fault_form_o),
    .cnt_o        (cnt)
  );

  assign fault_o    = flt_q;
  assign hit_cnt_o  = cnt[0];
  assign miss_cnt_o = cnt[1];
  assign acv_cnt_o  = cnt[2];
endmodule

// File: rtl/ift_xlate_chk.sv
module ift_xlate_chk
  import ift_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_IMPL_W = 44,
  parameter int CNT_W     = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             rsp_valid_o,
  input logic [VA_W-1:0]  paddr_o,
  input logic [1:0]       fault_o,
  input logic             uncached_o,
  input logic [VA_W-1:0]  fault_tag_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [CNT_W-1:0] acv_cnt_o
);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_hit_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hit_cnt_o) |-> rsp_valid_o && fault_o == FLT_NONE
                            && hit_cnt_o == CNT_W'($past(hit_cnt_o) + 1'b1));

  p_miss_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miss_cnt_o) |-> rsp_valid_o && fault_o == FLT_MISS
                             && miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1));

  p_acv_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acv_cnt_o) |-> rsp_valid_o && fault_o == FLT_ACV
                            && acv_cnt_o == CNT_W'($past(acv_cnt_o) + 1'b1));

  p_tag_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fault_tag_o) |-> rsp_valid_o && (fault_o == FLT_ACV || fault_o == FLT_MISS));

  p_fault_cached_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o != FLT_NONE |-> !uncached_o);

  p_pa_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o == FLT_NONE |-> paddr_o[VA_W-1:PA_IMPL_W] == '0);
endmodule

bind ift_xlate ift_xlate_chk #(.VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ift_xlate.sv
`timescale 1ns/1ps
module tb_ift_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic        phys_mode_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  sp_en_i = '0;
  logic [7:0]  asn_i = '0;
  logic [63:0] ptbr_i = 64'h0000_0002_0000_0000;
  logic [29:0] tb_vpn_o;
  logic [7:0]  tb_asn_o;
  logic        tb_hit_i = 1'b0;
  logic [30:0] tb_pfn_i = '0;
  logic [3:0]  tb_rd_en_i = '0;
  logic        rsp_valid_o;
  logic [63:0] paddr_o;
  logic [1:0]  fault_o;
  logic        uncached_o;
  logic [63:0] fault_tag_o, fault_form_o;
  logic [31:0] hit_cnt_o, miss_cnt_o, acv_cnt_o;

  int checks = 0;
  int failures = 0;
  int e_hit = 0, e_miss = 0, e_acv = 0;
  logic [63:0] e_tag = '0, e_form = '0;

  always #2 clk_i = ~clk_i;

  ift_xlate dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] va, input logic ph, input logic [1:0] md,
                       input logic [1:0] sp, input logic hit, input logic [30:0] pfn,
                       input logic [3:0] rd);
    vaddr_i = va; phys_mode_i = ph; mode_i = md; sp_en_i = sp;
    tb_hit_i = hit; tb_pfn_i = pfn; tb_rd_en_i = rd; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic chk_rsp(input string req, input logic [63:0] pa, input logic [1:0] f, input logic uc);
    chk(req, "rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
    chk(req, "paddr", paddr_o, pa);
    chk(req, "fault", {62'd0, fault_o}, {62'd0, f});
    chk(req, "uncached", {63'd0, uncached_o}, {63'd0, uc});
  endtask

  task automatic chk_side(input string req);
    chk(req, "hit_cnt", {32'd0, hit_cnt_o}, 64'(e_hit));
    chk(req, "miss_cnt", {32'd0, miss_cnt_o}, 64'(e_miss));
    chk(req, "acv_cnt", {32'd0, acv_cnt_o}, 64'(e_acv));
    chk(req, "fault_tag", fault_tag_o, e_tag);
    chk(req, "fault_form", fault_form_o, e_form);
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
    chk("R1", "paddr", paddr_o, 64'd0);
    chk("R1", "fault", {62'd0, fault_o}, 64'd0);
    chk("R1", "uncached", {63'd0, uncached_o}, 64'd0);
    chk_side("R1");
  endtask

  task automatic t_priv;
    // R3: bit 40 of the result is set, still cached
    issue(64'hFFFF_F123_4567_89AB, 1'b0, 2'd3, 2'b10, 1'b0, '0, '0);
    e_hit++;
    chk_rsp("R3", 64'h0000_0123_4567_89A8, 2'd0, 1'b0);
    chk_side("R3");
  endtask

  task automatic t_tb_hit;
    vaddr_i = 64'h0000_0000_0246_8ACE; asn_i = 8'h5A; #0.5;
    chk("R12", "tb_vpn", {34'd0, tb_vpn_o}, 64'h1234);
    chk("R12", "tb_asn", {56'd0, tb_asn_o}, 64'h5A);
    issue(64'h0000_0000_0246_8ACE, 1'b0, 2'd3, 2'b00, 1'b1, 31'h12345, 4'b1000);
    e_hit++;
    chk_rsp("R8", 64'h0000_0000_2468_AACC, 2'd0, 1'b0);
    chk_side("R8");
    issue(64'h0000_0000_0000_0104, 1'b0, 2'd0, 2'b00, 1'b1, 31'h0400_0001, 4'b0001);
    e_hit++;
    chk_rsp("R9", 64'h0000_0080_0000_2104, 2'd0, 1'b1);
    chk_side("R9");
  endtask

  task automatic t_tb_acv;
    issue(64'h0000_0000_0000_0104, 1'b0, 2'd3, 2'b00, 1'b1, 31'h0400_0001, 4'b0111);
    e_acv++; e_tag = 64'h104; e_form = 64'h0000_0002_0000_0000;
    chk_rsp("R8", 64'd0, 2'd1, 1'b0);
    chk_side("R10");
  endtask

  task automatic t_miss;
    // superpage disabled by bit 1 clear: goes to the buffer, which misses
    issue(64'hFFFF_FC00_1234_5678, 1'b0, 2'd0, 2'b01, 1'b0, '0, 4'hF);
    e_miss++; e_tag = 64'hFFFF_FC00_1234_5678; e_form = 64'h0000_0003_0004_8D10;
    chk_rsp("R8", 64'd0, 2'd2, 1'b0);
    chk_side("R11");
  endtask

  task automatic t_phys;
    issue(64'h0000_0080_0000_1000, 1'b1, 2'd3, 2'b00, 1'b0, '0, '0);
    chk_rsp("R4", 64'h0000_0080_0000_1000, 2'd0, 1'b1);
    chk_side("R4");
    issue(64'h0000_1000_0000_0000, 1'b1, 2'd3, 2'b00, 1'b0, '0, '0);
    chk_rsp("R9", 64'h0000_1000_0000_0000, 2'd3, 1'b0);
    chk_side("R10");
  endtask

  task automatic t_badva;
    issue(64'h0001_0000_0000_2000, 1'b0, 2'd0, 2'b00, 1'b1, 31'h1, 4'hF);
    e_acv++; e_tag = 64'h0001_0000_0000_2000; e_form = 64'h0000_0002_0000_0008;
    chk_rsp("R5", 64'd0, 2'd1, 1'b0);
    chk_side("R5");
  endtask

  task automatic t_spage;
    issue(64'hFFFF_FC80_1234_5678, 1'b0, 2'd0, 2'b10, 1'b0, '0, '0);
    chk_rsp("R6", 64'h0000_0F80_1234_5678, 2'd0, 1'b1);
    chk_side("R6");
    issue(64'hFFFF_FC00_1234_5678, 1'b0, 2'd0, 2'b10, 1'b0, '0, '0);
    chk_rsp("R6", 64'h0000_0000_1234_5678, 2'd0, 1'b0);
    issue(64'hFFFF_FC00_1234_5678, 1'b0, 2'd3, 2'b10, 1'b1, 31'h7, 4'hF);
    e_acv++; e_tag = 64'hFFFF_FC00_1234_5678; e_form = 64'h0000_0003_0004_8D10;
    chk_rsp("R7", 64'd0, 2'd1, 1'b0);
    chk_side("R7");
  endtask

  task automatic t_idle;
    vaddr_i = 64'h0001_0000_0000_2000; tb_hit_i = 1'b0; req_valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R2", "rsp_valid idle", {63'd0, rsp_valid_o}, 64'd0);
    chk_side("R2");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_priv();
    t_tb_hit();
    t_tb_acv();
    t_miss();
    t_phys();
    t_badva();
    t_spage();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule